// File: doc/BRIEF.md
# Master Vertical Sync Generator

This block produces the frame synchronisation pulse for a pixel input port whose timing is driven by the encoder. It runs on the pixel clock. It advances one line for every line-start strobe, which is the leading edge of horizontal sync. It reports the current line index and flags whether the current line belongs to the encoded picture.

A frame begins on the line where the counter is 0. The sync pulse covers that whole line, so its leading edge lines up with a horizontal sync leading edge. Software programs four settings: the total line count of a frame, the number of blanking lines that follow the sync edge, the number of active lines after those, and the pin polarity.

Blanking lines are held out of encoding. The active window then opens and stays open for the programmed number of lines. The settings are expected to be stable while the block runs. They must satisfy total ≥ 2 and blank + active ≤ total.

Top module: `vsync_master`

## Requirements
- R1: While reset is held, and until the first line strobe after reset, the line index is 0, the active flag is 0 and the sync pin is at its inactive level.
- R2: The first line strobe after reset starts a frame. The line index becomes 0 and sync becomes active.
- R3: Each later strobe increments the line index by one. The strobe seen while the index is total−1 returns it to 0.
- R4: Sync is active for exactly the line whose index is 0. Its leading edges are therefore exactly `cfg_total_lines` strobes apart.
- R5: The active flag is 1 exactly on lines with index from `cfg_blank_lines` to `cfg_blank_lines + cfg_active_lines − 1`. Blanking lines between the sync edge and the window read 0.
- R6: Every output is registered. Outputs change only in the clock cycle after a sampled strobe and hold steady between strobes.
- R7: When `cfg_vs_high` is 0 (the default), the sync pin is low while sync is active. When `cfg_vs_high` is 1, the pin is high while sync is active.
- R8: With a blanking count of 0, sync and the active flag rise on the same strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| line_start | input | 1 | One-cycle strobe at each horizontal sync leading edge |
| cfg_total_lines | input | LW | Lines per frame |
| cfg_blank_lines | input | LW | Lines from the sync edge to the first active line |
| cfg_active_lines | input | LW | Number of active lines |
| cfg_vs_high | input | 1 | Sync polarity: 0 = active low, 1 = active high |
| vsync_o | output | 1 | Vertical sync pin level |
| line_idx | output | LW | Current line index within the frame |
| v_active | output | 1 | Current line is to be encoded |

## Verification
The frame wrap and the start of the active window can land on the same strobe. This happens when the blanking count is 0. The bench sets up that case with a full-frame window (blank 0, active equal to total), so the active flag never drops and sync keeps returning on the same line. A second case uses a window that ends on the last line of the frame, so the active flag falls on the very strobe that raises sync. Each strobe pushes an expected line index, sync pin level and active flag into a queue. A monitor pops and compares them in the cycle after the strobe.

// File: rtl/vsync_master.sv
module vsync_master #(
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start,
  input  logic [LW-1:0] cfg_total_lines,
  input  logic [LW-1:0] cfg_blank_lines,
  input  logic [LW-1:0] cfg_active_lines,
  input  logic          cfg_vs_high,
  output logic          vsync_o,
  output logic [LW-1:0] line_idx,
  output logic          v_active
);

  logic          running;
  logic [LW-1:0] line_q;
  logic          vs_q;
  logic          va_q;

  logic [LW-1:0] last_line;
  logic [LW-1:0] line_nx;
  logic [LW:0]   win_end;
  logic          va_nx;

  assign last_line = cfg_total_lines - 1'b1;
  assign line_nx   = (!running || line_q == last_line) ? '0 : line_q + 1'b1;
  assign win_end   = {1'b0, cfg_blank_lines} + {1'b0, cfg_active_lines};
  assign va_nx     = (line_nx >= cfg_blank_lines) && ({1'b0, line_nx} < win_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      line_q  <= '0;
      vs_q    <= 1'b0;
      va_q    <= 1'b0;
    end else if (line_start) begin
      running <= 1'b1;
      line_q  <= line_nx;
      vs_q    <= (line_nx == '0);
      va_q    <= va_nx;
    end
  end

  assign vsync_o  = cfg_vs_high ? vs_q : ~vs_q;
  assign line_idx = line_q;
  assign v_active = va_q;

  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !running |-> (!vs_q && !va_q && line_q == '0));

  p_first_frame_r2: assert property (@(posedge clk) disable iff (rst)
    (line_start && !running) |=> (vs_q && line_q == '0));

  p_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    running |-> (line_q < cfg_total_lines));

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (line_start && running && line_q == last_line) |=> (line_q == '0 && vs_q));

  p_one_line_r4: assert property (@(posedge clk) disable iff (rst)
    (line_start && vs_q) |=> !vs_q);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> ($stable(line_q) && $stable(vs_q) && $stable(va_q)));

  p_blank_r5: assert property (@(posedge clk) disable iff (rst)
    (running && line_q < cfg_blank_lines) |-> !va_q);

endmodule

// File: tb/vsync_master_test.sv
module vsync_master_test;
  localparam int LW = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          line_start = 1'b0;
  logic [LW-1:0] cfg_total_lines = 10;
  logic [LW-1:0] cfg_blank_lines = 3;
  logic [LW-1:0] cfg_active_lines = 5;
  logic          cfg_vs_high = 1'b0;
  logic          vsync_o;
  logic [LW-1:0] line_idx;
  logic          v_active;

  always #4 clk = ~clk;

  vsync_master #(.LW(LW)) uut (
    .clk(clk), .rst(rst), .line_start(line_start),
    .cfg_total_lines(cfg_total_lines), .cfg_blank_lines(cfg_blank_lines),
    .cfg_active_lines(cfg_active_lines), .cfg_vs_high(cfg_vs_high),
    .vsync_o(vsync_o), .line_idx(line_idx), .v_active(v_active)
  );

  int checks = 0;
  int errors = 0;
  logic [LW+1:0] expq[$];
  logic [LW+1:0] last_exp;
  logic          have_last = 1'b0;
  logic          chk_due = 1'b0;
  bit            m_run;
  int            m_line;
  int            vs_edges;

  task automatic check(input string req, input logic [LW+1:0] act, input logic [LW+1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual line=%0d vs=%0b va=%0b expected line=%0d vs=%0b va=%0b",
               req, act[LW+1:2], act[1], act[0], exp[LW+1:2], exp[1], exp[0]);
    end
  endtask

  function automatic logic [LW+1:0] pack_exp(input int ln);
    logic act, va;
    act = (ln == 0);
    va  = (ln >= cfg_blank_lines) && (ln < cfg_blank_lines + cfg_active_lines);
    return {ln[LW-1:0], cfg_vs_high ? act : ~act, va};
  endfunction

  always @(posedge clk) chk_due <= line_start && !rst;

  always @(negedge clk) begin
    if (chk_due && expq.size() > 0) begin
      last_exp = expq.pop_front();
      have_last = 1'b1;
      check("R3/R4/R5 strobe", {line_idx, vsync_o, v_active}, last_exp);
    end else if (have_last && !rst) begin
      check("R6 hold", {line_idx, vsync_o, v_active}, last_exp);
    end
  end

  task automatic strobe(input int gap);
    @(negedge clk);
    line_start = 1'b1;
    m_line = !m_run ? 0 : (m_line == cfg_total_lines - 1 ? 0 : m_line + 1);
    m_run = 1'b1;
    if (m_line == 0) vs_edges++;
    expq.push_back(pack_exp(m_line));
    @(negedge clk);
    line_start = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_reset(input int t, input int b, input int a, input logic pol);
    @(negedge clk);
    rst = 1'b1;
    have_last = 1'b0;
    cfg_total_lines = t; cfg_blank_lines = b; cfg_active_lines = a; cfg_vs_high = pol;
    repeat (3) @(negedge clk);
    // R1: reset state visible while held
    check("R1 in reset", {line_idx, vsync_o, v_active}, {{LW{1'b0}}, ~pol, 1'b0});
    rst = 1'b0;
    m_run = 1'b0; m_line = 0; vs_edges = 0;
    repeat (4) @(negedge clk);
    // R1: still idle before the first strobe
    check("R1 idle", {line_idx, vsync_o, v_active}, {{LW{1'b0}}, ~pol, 1'b0});
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R2, R3, R4, R5, R7 active low: 10 lines, blank 3, active 5
    do_reset(10, 3, 5, 1'b0);
    for (int i = 0; i < 25; i++) strobe(i % 4);
    // R4: leading edges every cfg_total_lines strobes: 25 strobes -> 3 frame starts
    checks++;
    if (vs_edges != 3) begin errors++; $display("FAIL R4: actual %0d expected 3", vs_edges); end

    // R7 active high, R8 blank 0 with window covering the whole frame
    do_reset(6, 0, 6, 1'b1);
    for (int i = 0; i < 14; i++) strobe(1);

    // Window ending on the last line: active falls as sync rises (R5, R4)
    do_reset(8, 2, 6, 1'b0);
    for (int i = 0; i < 18; i++) strobe(2);

    // Smallest frame, R3 wrap every two lines
    do_reset(2, 1, 1, 1'b1);
    for (int i = 0; i < 7; i++) strobe(0);

    repeat (3) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin errors++; $display("FAIL R6: actual %0d pending expected 0", expq.size()); end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule